// File: doc/BRIEF.md
# Interrupt Acknowledge Chip Select

This block decodes the processor's interrupt acknowledge read. That read is issued in the CPU address space, with the upper address lines all driven high and the level being acknowledged on address bits 3:1. When the block sees a matching acknowledge read, it drives an active-low select line to a peripheral's acknowledge input. The peripheral then answers by placing its 8-bit vector number on the data bus.

The block can also end the bus cycle itself. In vector mode it raises the data-transfer acknowledge after a programmed number of wait states, which gives the peripheral time to drive its vector. In autovector mode it raises the autovector line at once, so the processor fetches its own vector. A third setting turns the select off.

The select responds only to CPU-space reads. It therefore cannot also end ordinary user-space or supervisor-space accesses. Every output drops in the same cycle that the address strobe is released.

Top module: `iack_select`

## Requirements
- R1: `cs_n` is low only while all of these hold: `as_n` is low, `rw` is 1 (read), `fc` is 3'b111 (CPU space), and `addr[23:4]` is all ones.
- R2: The select matches only when `base_reg[15:4]` is 12'hFFF. With any other value in those bits, all three outputs stay high.
- R3: When `cfg_level` is 0 to 6, `addr[3:1]` must equal `cfg_level` for a match. When `cfg_level` is 3'b111, every level matches.
- R4: When `cfg_resp` is 2'b01 (vector mode), the block ends a matched cycle by driving `dsack_n` low, and `avec_n` stays high.
- R5: When `cfg_resp` is 2'b10 (autovector mode), `avec_n` goes low in the same cycle as `cs_n`, and `dsack_n` stays high.
- R6: In vector mode, `dsack_n` goes low after W rising clock edges of continuous selection. W is `cfg_wait`, and values above 13 are treated as 13. When W is 0, `dsack_n` goes low in the same cycle as `cs_n`.
- R7: Cycles with a user-space or supervisor-space function code (1, 2, 5, 6) never drive any output low, even when the address is all ones.
- R8: When `as_n` goes high, `cs_n`, `dsack_n` and `avec_n` go high in the same cycle. The wait count then starts again from zero for the next cycle.
- R9: When `cfg_resp` is 2'b00 or 2'b11 (off), no output is ever driven low.
- R10: While `rst_n` is low, all outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 24 | Bus address |
| fc | input | 3 | Function code (3'b111 = CPU space) |
| as_n | input | 1 | Address strobe, active low |
| rw | input | 1 | 1 = read |
| base_reg | input | 16 | Base address register (bits 15:4 must be 12'hFFF) |
| cfg_resp | input | 2 | 01 = vector mode, 10 = autovector mode, 00/11 = off |
| cfg_level | input | 3 | Acknowledge level to match (111 = any level) |
| cfg_wait | input | 4 | Wait states before DSACK (values above 13 act as 13) |
| cs_n | output | 1 | Select to the peripheral's acknowledge input, active low |
| dsack_n | output | 1 | Internal data-transfer acknowledge, active low |
| avec_n | output | 1 | Internal autovector, active low |

## Verification
The bench checks the wait-state edges by confirming that `dsack_n` is still high one edge before W and low exactly at W. It does this for W values of 0, 3 and 15. The case W = 15 catches a design that does not clamp the count and so holds the cycle two extra edges.

Back-to-back acknowledge cycles show whether the counter restarts when `as_n` is released. A design that keeps the count would answer the second cycle too early.

Further cases cover the following:
- Supervisor and user reads to the all-ones address, and a CPU-space write. A design that decodes only the address would select on these.
- A base register that is not programmed to the acknowledge pattern.
- A level mismatch, and the wildcard level value.
- The off setting, and release of the strobe in the middle of a cycle. A design with a registered select would still be asserting during that release cycle.

// File: rtl/iack_select.sv
module iack_select #(
  parameter int ADDR_W   = 24,
  parameter int WAIT_W   = 4,
  parameter int MAX_WAIT = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        fc,
  input  logic              as_n,
  input  logic              rw,
  input  logic [ADDR_W-9:0] base_reg,
  input  logic [1:0]        cfg_resp,
  input  logic [2:0]        cfg_level,
  input  logic [WAIT_W-1:0] cfg_wait,
  output logic              cs_n,
  output logic              dsack_n,
  output logic              avec_n
);
  localparam int BASE_W = ADDR_W - 8;
  localparam logic [2:0] FC_CPU = 3'b111;
  localparam logic [1:0] RESP_VEC = 2'b01;
  localparam logic [1:0] RESP_AUTO = 2'b10;
  localparam logic [WAIT_W-1:0] WAIT_CAP = WAIT_W'(MAX_WAIT);
  localparam logic [WAIT_W-1:0] CNT_TOP = '1;

  logic enabled, space_ok, addr_ok, base_ok, level_ok, hit;
  logic [WAIT_W-1:0] cnt, wait_eff;

  assign enabled  = (cfg_resp == RESP_VEC) || (cfg_resp == RESP_AUTO);
  assign space_ok = (fc == FC_CPU) && rw && !as_n;
  assign addr_ok  = &addr[ADDR_W-1:4];
  assign base_ok  = &base_reg[BASE_W-1:4];
  assign level_ok = (cfg_level == 3'b111) || (addr[3:1] == cfg_level);
  assign hit      = rst_n && enabled && space_ok && addr_ok && base_ok && level_ok;

  assign wait_eff = (cfg_wait > WAIT_CAP) ? WAIT_CAP : cfg_wait;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!hit)       cnt <= '0;
    else if (cnt != CNT_TOP) cnt <= cnt + 1'b1;
  end

  assign cs_n    = !hit;
  assign dsack_n = !(hit && (cfg_resp == RESP_VEC) && (cnt >= wait_eff));
  assign avec_n  = !(hit && (cfg_resp == RESP_AUTO));

  AST_TERM_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dsack_n && !avec_n)); // R4
  AST_TERM_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!dsack_n || !avec_n) |-> !cs_n); // R5
  AST_NON_CPU_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (fc != FC_CPU) |-> (cs_n && dsack_n && avec_n)); // R7
  AST_STROBE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    as_n |-> (cs_n && dsack_n && avec_n)); // R8
  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |-> (cs_n && dsack_n && avec_n)); // R9
  AST_WAIT_AFTER_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!dsack_n && cfg_wait != '0) |-> $past(!cs_n)); // R6
  AST_BASE_REQUIRED: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> base_ok); // R2
endmodule

// File: tb/iack_select_tb.sv
module iack_select_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [23:0] addr = 24'h0;
  logic [2:0] fc = 3'd0;
  logic as_n = 1, rw = 1;
  logic [15:0] base_reg = 16'hFFF0;
  logic [1:0] cfg_resp = 2'b01;
  logic [2:0] cfg_level = 3'b111;
  logic [3:0] cfg_wait = 4'd0;
  logic cs_n, dsack_n, avec_n;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iack_select u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .fc(fc), .as_n(as_n), .rw(rw),
    .base_reg(base_reg), .cfg_resp(cfg_resp), .cfg_level(cfg_level),
    .cfg_wait(cfg_wait), .cs_n(cs_n), .dsack_n(dsack_n), .avec_n(avec_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic begin_cycle(input logic [23:0] a, input logic [2:0] f, input logic r);
    @(negedge clk);
    addr = a; fc = f; rw = r; as_n = 0;
    #1;
  endtask

  task automatic end_cycle();
    @(negedge clk);
    as_n = 1;
    #1;
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    as_n = 0; addr = 24'hFFFFFF; fc = 3'b111;
    #1;
    chk("R10 outputs high in reset", {cs_n, dsack_n, avec_n}, 3'b111);
    as_n = 1;
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
  endtask

  task automatic t_vector(input logic [3:0] w, input int expect_edges);
    cfg_resp = 2'b01; cfg_level = 3'b111; cfg_wait = w;
    begin_cycle(24'hFFFFF6, 3'b111, 1);
    chk("R1 select on CPU-space ack read", cs_n, 0);
    chk("R4 avec_n high in vector mode", avec_n, 1);
    for (int i = 0; i < expect_edges; i++) begin
      chk("R6 dsack_n still high before wait ends", dsack_n, 1);
      @(posedge clk); #1;
    end
    chk("R6 dsack_n low after wait states", dsack_n, 0);
    chk("R4 avec_n stays high", avec_n, 1);
    end_cycle();
  endtask

  task automatic t_autovec();
    cfg_resp = 2'b10; cfg_wait = 4'd5;
    begin_cycle(24'hFFFFF2, 3'b111, 1);
    chk("R5 avec_n low with select", {cs_n, avec_n}, 2'b00);
    @(posedge clk); #1; @(posedge clk); #1;
    chk("R5 dsack_n high in autovector mode", dsack_n, 1);
    end_cycle();
    cfg_resp = 2'b01;
  endtask

  task automatic t_level();
    cfg_resp = 2'b01; cfg_wait = 0; cfg_level = 3'd3;
    begin_cycle(24'hFFFFF6, 3'b111, 1);
    chk("R3 level 3 matches addr[3:1]=3", {cs_n, dsack_n}, 2'b00);
    end_cycle();
    begin_cycle(24'hFFFFF4, 3'b111, 1);
    chk("R3 level mismatch ignored", {cs_n, dsack_n, avec_n}, 3'b111);
    end_cycle();
    cfg_level = 3'b111;
    begin_cycle(24'hFFFFF4, 3'b111, 1);
    chk("R3 wildcard level matches", cs_n, 0);
    end_cycle();
  endtask

  task automatic t_base();
    base_reg = 16'hFFE0;
    begin_cycle(24'hFFFFF2, 3'b111, 1);
    chk("R2 wrong base gives no select", {cs_n, dsack_n, avec_n}, 3'b111);
    end_cycle();
    base_reg = 16'hFFF7;
    begin_cycle(24'hFFFFF2, 3'b111, 1);
    chk("R2 low base bits are don't care", cs_n, 0);
    end_cycle();
    base_reg = 16'hFFF0;
  endtask

  task automatic t_space();
    logic [2:0] codes [4] = '{3'd1, 3'd2, 3'd5, 3'd6};
    for (int i = 0; i < 4; i++) begin
      begin_cycle(24'hFFFFFE, codes[i], 1);
      @(posedge clk); #1;
      chk("R7 user/supervisor cycle ignored", {cs_n, dsack_n, avec_n}, 3'b111);
      end_cycle();
    end
    begin_cycle(24'hFFFFFE, 3'b111, 0);
    chk("R1 CPU-space write ignored", {cs_n, dsack_n}, 2'b11);
    end_cycle();
    begin_cycle(24'hFFFEFE, 3'b111, 1);
    chk("R1 address not all ones ignored", cs_n, 1);
    end_cycle();
  endtask

  task automatic t_disabled();
    cfg_resp = 2'b00;
    begin_cycle(24'hFFFFFE, 3'b111, 1);
    @(posedge clk); #1;
    chk("R9 resp 00 no outputs", {cs_n, dsack_n, avec_n}, 3'b111);
    end_cycle();
    cfg_resp = 2'b11;
    begin_cycle(24'hFFFFFE, 3'b111, 1);
    @(posedge clk); #1;
    chk("R9 resp 11 no outputs", {cs_n, dsack_n, avec_n}, 3'b111);
    end_cycle();
    cfg_resp = 2'b01;
  endtask

  task automatic t_release();
    cfg_resp = 2'b01; cfg_wait = 4'd2;
    begin_cycle(24'hFFFFFE, 3'b111, 1);
    @(posedge clk); #1;
    @(negedge clk); as_n = 1; #1;
    chk("R8 outputs drop with strobe", {cs_n, dsack_n, avec_n}, 3'b111);
    @(posedge clk); #1;
    begin_cycle(24'hFFFFFE, 3'b111, 1);
    @(posedge clk); #1;
    chk("R8 count restarts after release", dsack_n, 1);
    @(posedge clk); #1;
    chk("R8 dsack after full wait in new cycle", dsack_n, 0);
    @(negedge clk); as_n = 1; #1;
    chk("R8 dsack drops same cycle as strobe", {cs_n, dsack_n}, 2'b11);
    @(posedge clk); #1;
  endtask

  initial begin
    t_reset();
    t_vector(4'd0, 0);
    t_vector(4'd3, 3);
    t_vector(4'd13, 13);
    t_vector(4'd15, 13);
    t_autovec();
    t_level();
    t_base();
    t_space();
    t_disabled();
    t_release();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule